// File: doc/BRIEF.md
# Software-Refreshed Watchdog Timer

This block guards against runaway software. Once running, a 15-bit up-counter advances on a slow tick taken from the system clock. If the counter wraps past its all-ones value, the block raises a one-cycle reset request and sets a sticky flag recording that the watchdog caused the reset. Software keeps the counter away from the wrap by refreshing it with two bus writes to the control register in a set order. A refresh also reloads the upper counter bits from a programmable reload register. The most significant bit of that register adds a further divide-by-16 on the tick.

The block starts in one of two ways. It runs from reset if a strap input is high while reset is asserted. Otherwise software starts it with its first completed refresh. Software cannot stop it; only a reset, or the block's own expiry, returns it to the strap-selected default. A halt input freezes the tick and the counter while the system sleeps.

On expiry the block restarts itself: the counter returns to zero, the reload register to zero, and the run state to the strap value. The cause flag is set. The external reset `rst` clears the flag.

Top module: `wdog_guard`

## Requirements
- R1: While `rst` is high, the block samples `start_pin` into its run state and clears the counter, the reload register, the refresh stage and the cause flag; `bite` is low. Read map: address 0 (control) returns bit 0 = refresh stage armed, bit 2 = running, bit 3 = cause flag, other bits 0; address 1 returns the reload register; address 2 returns counter bits 14..8 zero-extended; reads have one cycle of latency and no side effects.
- R2: A write to address 0 with bit 1 set, when the previous bus write was to address 0 with bit 0 set, is a refresh. A refresh loads the counter with the reload register's bits 6..0 in counter bits 14..8 and zeros below. It restarts the tick divider and sets the running state.
- R3: A write with bit 1 set does not refresh when no armed write precedes it, or when another bus write (any address or data) comes between the two writes. Idle cycles and reads between the two writes do not break the sequence.
- R4: With reload bit 7 clear, the counter advances once every 12 clocks. After a refresh sampled at edge k, `bite` is high for exactly one cycle, following edge k + (32768 − 256·R)·12, where R is reload bits 6..0.
- R5: With reload bit 7 set at the refresh, each counter step takes 12·16 clocks.
- R6: While `halt` is high, the tick divider and the counter hold. Expiry is delayed by exactly the number of halted cycles.
- R7: When `start_pin` was low during reset, the counter stays at zero and no `bite` occurs until software refreshes.
- R8: Once running, no bus write stops the watchdog.
- R9: On expiry the cause flag is set. The counter and reload register return to zero, the refresh stage clears, and the running state takes the present `start_pin` value.
- R10: `rst` clears the cause flag.
- R11: If a refresh is sampled on the same edge as the expiring tick, the refresh wins: no `bite`, and the counter reloads.
- R12: A write to the reload register does not change the counter or the tick rate until the next refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| start_pin | input | 1 | Strap: high starts the watchdog from reset |
| halt | input | 1 | Freezes counting during idle or power-down |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bite | output | 1 | One-cycle reset request on expiry |

## Verification
The refresh that completes the two-write sequence and the tick that would wrap the counter can land on the same clock edge. The bench provokes this by counting cycles from a known refresh. It times the arming write and the completing write so that the completing write is sampled exactly on the expiring edge. It then checks that no `bite` appears there, and that the next `bite` comes one full period after that edge, which proves the counter reloaded instead of wrapping.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

  // control register bit positions
  localparam int B_ARM   = 0;  // first step of the refresh pair
  localparam int B_FIRE  = 1;  // second step of the refresh pair
  localparam int B_RUN   = 2;  // read only: running
  localparam int B_CAUSE = 3;  // read only: last restart came from expiry
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int BASE_DIV = 12,
  parameter int PRE_DIV  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic halt_i,
  input  logic clear_i,
  input  logic psel_i,
  output logic tick_o
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [BW-1:0] base_q;
  logic          base_end;
  logic          go;
  logic          base_tick;

  assign go        = run_i && !halt_i;
  assign base_end  = (base_q == BW'(BASE_DIV - 1));
  assign base_tick = go && base_end;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      base_q <= '0;
    end else if (go) begin
      base_q <= base_end ? '0 : base_q + 1'b1;
    end
  end

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      logic          pre_end;
      assign pre_end = (pre_q == PW'(PRE_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clear_i) begin
          pre_q <= '0;
        end else if (base_tick && psel_i) begin
          pre_q <= pre_end ? '0 : pre_q + 1'b1;
        end
      end
      assign tick_o = base_tick && (!psel_i || pre_end);
    end else begin : g_nopre
      assign tick_o = base_tick;
    end
  endgenerate

  generate
    if (BASE_DIV > 1) begin : g_chk
      // R4: base ticks are never back to back
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        base_tick |=> !base_tick);
    end
  endgenerate
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 15,
  parameter int RLD_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pin_i,
  input  logic             halt_i,
  input  logic             tick_i,
  input  logic             refresh_i,
  input  logic [RLD_W:0]   reload_i,
  output logic             running_o,
  output logic             psel_o,
  output logic             cause_o,
  output logic             wrap_o,
  output logic             bite_o,
  output logic [RLD_W-1:0] count_hi_o
);
  localparam int LOW_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             psel_q;
  logic             cause_q;
  logic             bite_q;

  // refresh outranks the expiring tick (R11)
  assign wrap_o = tick_i && (&cnt_q) && !refresh_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= start_pin_i;
      psel_q  <= 1'b0;
      cause_q <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      bite_q <= wrap_o;
      if (wrap_o) begin
        cnt_q   <= '0;
        run_q   <= start_pin_i;
        psel_q  <= 1'b0;
        cause_q <= 1'b1;
      end else if (refresh_i) begin
        cnt_q  <= {reload_i[RLD_W-1:0], {LOW_W{1'b0}}};
        run_q  <= 1'b1;
        psel_q <= reload_i[RLD_W];
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign running_o  = run_q;
  assign psel_o     = psel_q;
  assign cause_o    = cause_q;
  assign bite_o     = bite_q;
  assign count_hi_o = cnt_q[CNT_W-1 -: RLD_W];

  p_bite_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    bite_q |=> !bite_q);
  p_bite_flag_r9: assert property (@(posedge clk) disable iff (rst)
    bite_q |-> cause_q);
  p_refresh_load_r2: assert property (@(posedge clk) disable iff (rst)
    refresh_i |=> (cnt_q == {$past(reload_i[RLD_W-1:0]), {LOW_W{1'b0}}}) && run_q);
  p_keep_running_r8: assert property (@(posedge clk) disable iff (rst)
    run_q && !wrap_o |=> run_q);
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    halt_i && !refresh_i |=> $stable(cnt_q));
  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !run_q && !refresh_i |=> $stable(cnt_q) && !bite_q);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RLD_W  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wrap_i,
  input  logic              running_i,
  input  logic              cause_i,
  input  logic [RLD_W-1:0]  count_hi_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              refresh_o,
  output logic [DATA_W-1:0] reload_o
);
  logic              arm_q;
  logic [DATA_W-1:0] rld_q;
  logic              ctrl_wr;
  logic [DATA_W-1:0] ctrl_view;

  assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
  assign refresh_o = ctrl_wr && bus_wdata[B_FIRE] && arm_q;

  always_ff @(posedge clk) begin
    if (rst || wrap_i) begin
      arm_q <= 1'b0;
      rld_q <= '0;
    end else if (bus_we) begin
      // every write either arms the pair or breaks it
      arm_q <= ctrl_wr && bus_wdata[B_ARM] && !refresh_o;
      if (bus_addr == A_RELOAD) rld_q <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[B_ARM]   = arm_q;
    ctrl_view[B_RUN]   = running_i;
    ctrl_view[B_CAUSE] = cause_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= ctrl_view;
        A_RELOAD: bus_rdata <= rld_q;
        A_COUNT:  bus_rdata <= {{(DATA_W-RLD_W){1'b0}}, count_hi_i};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign reload_o = rld_q;

  // R3: a write that is not an arming control write leaves the pair disarmed
  p_arm_broken_r3: assert property (@(posedge clk) disable iff (rst)
    bus_we && !(ctrl_wr && bus_wdata[B_ARM]) |=> !arm_q);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 15,
  parameter int BASE_DIV = 12,
  parameter int PRE_DIV  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_pin,
  input  logic              halt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bite
);
  localparam int RLD_W = DATA_W - 1;

  logic              refresh;
  logic              wrap;
  logic              running;
  logic              psel;
  logic              cause;
  logic              tick;
  logic [DATA_W-1:0] reload;
  logic [RLD_W-1:0]  count_hi;

  wdog_regs #(.DATA_W(DATA_W), .RLD_W(RLD_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wrap_i(wrap), .running_i(running), .cause_i(cause), .count_hi_i(count_hi),
    .bus_rdata(bus_rdata), .refresh_o(refresh), .reload_o(reload)
  );

  wdog_tick #(.BASE_DIV(BASE_DIV), .PRE_DIV(PRE_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(running), .halt_i(halt),
    .clear_i(refresh || wrap), .psel_i(psel), .tick_o(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_core (
    .clk(clk), .rst(rst), .start_pin_i(start_pin), .halt_i(halt),
    .tick_i(tick), .refresh_i(refresh), .reload_i(reload),
    .running_o(running), .psel_o(psel), .cause_o(cause),
    .wrap_o(wrap), .bite_o(bite), .count_hi_o(count_hi)
  );
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_pin = 1'b0;
  logic       halt = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       bite;

  wdog_guard u_wdog_guard (
    .clk(clk), .rst(rst), .start_pin(start_pin), .halt(halt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bite(bite)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    last_wr = 0;
  int    bite_cnt = 0;
  int    bite_wide = 0;
  logic  bite_prev = 1'b0;
  logic  rd_go = 1'b0;
  logic  rd_seen = 1'b0;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= rd_go;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the registered read returns
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        check("scoreboard underflow", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, int'(bus_rdata), int'(it.exp));
      end
    end
    if (bite) begin
      bite_cnt++;
      if (bite_prev) bite_wide++;
    end
    bite_prev = bite;
  end

  // drivers: called at a negedge, return at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    last_wr = cyc;
  endtask

  task automatic wr_at(input logic [1:0] a, input logic [7:0] d, input int t);
    while (cyc < t - 1) @(negedge clk);
    wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    bus_addr = a;
    sb_q.push_back(it);
    rd_go = 1'b1;
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  task automatic pulse_rst();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic refresh_pair();
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h02);
  endtask

  task automatic expect_bite(input int t, input string tag);
    int mark;
    mark = bite_cnt;
    if (cyc >= t - 1) check({tag, " target already passed"}, cyc, t - 1);
    while (cyc < t - 1) @(negedge clk);
    check({tag, " no early bite"}, bite_cnt, mark);
    check({tag, " bite low before expiry"}, int'(bite), 0);
    @(negedge clk);
    check({tag, " bite on expiry"}, int'(bite), 1);
    @(negedge clk);
    check({tag, " R4 bite one cycle"}, int'(bite), 0);
  endtask

  task automatic finish_run();
    while (sb_q.size() != 0) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state with strap low
    check("R1 bite low after reset", int'(bite), 0);
    rd(2'd0, 8'h00, "R1 control");
    rd(2'd1, 8'h00, "R1 reload");
    rd(2'd2, 8'h00, "R1 count");

    // R7: stopped watchdog stays still
    repeat (600) @(negedge clk);
    rd(2'd2, 8'h00, "R7 count held");
    rd(2'd0, 8'h00, "R7 not running");
    check("R7 no bite while stopped", bite_cnt, 0);

    // R12: reload write alone does not touch the counter
    wr(2'd1, 8'h7F);
    rd(2'd2, 8'h00, "R12 count unchanged");
    rd(2'd1, 8'h7F, "R12 reload readback");

    // R3: lone fire write does not start or refresh
    wr(2'd0, 8'h02);
    rd(2'd0, 8'h00, "R3 lone fire ignored");

    // R2: arm, a read in between, then fire; R3 reads do not break it
    wr(2'd0, 8'h01);
    rd(2'd0, 8'h01, "R3 arm visible");
    wr(2'd0, 8'h02);
    k = last_wr;
    rd(2'd0, 8'h04, "R2 running after refresh");
    rd(2'd2, 8'h7F, "R2 count loaded");

    // R3: broken sequences must not move the expiry
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h7F);
    wr(2'd0, 8'h02);
    // R8: software cannot stop it
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd0, 8'h04, "R8 still running");
    expect_bite(k + 3072, "R3 R4");

    // R9: restart after expiry, strap low
    rd(2'd0, 8'h08, "R9 cause set, stopped");
    rd(2'd1, 8'h00, "R9 reload cleared");
    rd(2'd2, 8'h00, "R9 count cleared");

    // R10: external reset clears flag; strap high auto-starts (R1)
    start_pin = 1'b1;
    pulse_rst();
    rd(2'd0, 8'h04, "R10 cause cleared, R1 auto running");
    rd(2'd2, 8'h00, "R10 count from zero");

    // R6: halt delays expiry by the halted cycles
    wr(2'd1, 8'h7F);
    refresh_pair();
    k = last_wr;
    repeat (100) @(negedge clk);
    halt = 1'b1;
    repeat (1000) @(negedge clk);
    halt = 1'b0;
    expect_bite(k + 3072 + 1000, "R6");
    rd(2'd0, 8'h0C, "R9 restart with strap high");

    // R11: refresh lands on the expiring edge
    wr(2'd1, 8'h7F);
    refresh_pair();
    k = last_wr;
    wr_at(2'd0, 8'h01, k + 3071);
    wr_at(2'd0, 8'h02, k + 3072);
    check("R11 refresh sampled on expiry edge", last_wr, k + 3072);
    expect_bite(last_wr + 3072, "R11");

    // R5: prescaler bit
    wr(2'd1, 8'hFF);
    refresh_pair();
    k = last_wr;
    rd(2'd2, 8'h7F, "R5 count loaded");
    expect_bite(k + 256 * 12 * 16, "R5");

    check("R4 bite never wider than one cycle", bite_wide, 0);
    finish_run();
  end
endmodule